// File: doc/BRIEF.md
# Prioritized Transmit Queue Scheduler

This block picks which transmit descriptor goes out next. It watches sixteen circular descriptor rings and sends the chosen descriptor to one of eight output channels. Each ring keeps a small context: the channel it feeds, an active flag, a traffic identifier, a receiver index, a window size and a frame limit. Each ring also keeps an 8-bit write pointer, which the host sets, and an 8-bit read pointer, which the block advances.

Several rings may feed the same channel. The channels rank by priority. The command channel comes first. The four traffic channels follow, with voice above video, video above best effort, and best effort above background. The spare channels rank last. When more than one ring is waiting on the winning channel, those rings take turns.

Only one grant is open at a time. The grant carries the ring number, the descriptor index and the ring's context fields. It stays unchanged until the consumer accepts it. The accept retires that descriptor.

Top module: `txsched_top`

## Requirements
- R1: During and right after a synchronous reset, `gnt_valid` is low. Reset sets every ring to inactive, on channel 0, with both pointers at 0, traffic identifier 0 and receiver index 0.
- R2: A ring can be granted only when its active flag is set and its write pointer differs from its read pointer. An inactive ring that holds entries is never granted.
- R3: When several channels have eligible rings, the grant goes to the highest-ranked one. Ranking from highest to lowest: channel 7, then 3, 2, 1, 0, then 6, 5, 4.
- R4: Rings that share the winning channel are served round-robin. The search starts at the ring number just above the one last accepted on that channel, wrapping from 15 to 0. After reset, the search starts at ring 0.
- R5: A grant holds all of its outputs steady until `gnt_accept` is high at a clock edge. At that edge the ring's read pointer advances by one, wrapping from 255 to 0, and `gnt_valid` is low in the following cycle.
- R6: A status write (`cfg_kind` = 0) takes effect only when bit 19 of `cfg_wdata` is 1. It then loads the channel from bits [2:0] and the active flag from bit 3. When bit 19 is 0, the write changes nothing.
- R7: While a ring is active, a status write leaves its channel unchanged. The same write still updates the active flag.
- R8: A map write (`cfg_kind` = 1) loads the traffic identifier from bits [3:0] and the receiver index from bits [8:4]. Both are presented with the ring's grants.
- R9: A limits write (`cfg_kind` = 2) loads the window size from bits [6:0] and the frame limit from bits [22:16]. Both fields reset to 64 and are presented with the ring's grants.
- R10: A write to the write pointer (`wp_we`) loads `wp_val` as that ring's new write pointer, and the ring's outstanding entries run from its read pointer up to this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Context write strobe |
| cfg_kind | input | 2 | Write kind: 0 status, 1 map, 2 limits, 3 none |
| cfg_qid | input | 4 | Ring addressed by the context write |
| cfg_wdata | input | 32 | Context write data |
| wp_we | input | 1 | Write-pointer update strobe |
| wp_qid | input | 4 | Ring whose write pointer is updated |
| wp_val | input | 8 | New write pointer value |
| gnt_valid | output | 1 | A grant is being presented |
| gnt_accept | input | 1 | Consumer takes the presented grant |
| gnt_qid | output | 4 | Granted ring |
| gnt_ch | output | 3 | Output channel of the granted ring |
| gnt_idx | output | 8 | Descriptor index (read pointer) |
| gnt_tid | output | 4 | Traffic identifier of the granted ring |
| gnt_rcv | output | 5 | Receiver index of the granted ring |
| gnt_win | output | 7 | Window size of the granted ring |
| gnt_flim | output | 7 | Frame limit of the granted ring |

## Verification
The assertions assume `gnt_accept` is raised only while a grant is shown. They also assume the host never sets a write pointer more than 255 entries ahead of the read pointer, because a full ring would look empty. The bench raises accept only after it has seen `gnt_valid` high. It keeps every ring's backlog well under the ring size, and it sets up multi-ring contests with accept held low, so the order of contenders is fixed when arbitration resumes.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    localparam int NUM_Q   = 16;
    localparam int NUM_CH  = 8;
    localparam int NUM_AC  = 4;          // traffic channels 0..NUM_AC-1
    localparam int CMD_CH  = 7;
    localparam int PTR_W   = 8;
    localparam int DATA_W  = 32;
    localparam int TID_W   = 4;
    localparam int RCV_W   = 5;
    localparam int LIM_W   = 7;
    localparam int DEF_LIM = 64;
    localparam int Q_W     = $clog2(NUM_Q);
    localparam int CH_W    = $clog2(NUM_CH);

    // field positions inside configuration words
    localparam int ST_CH_LSB   = 0;
    localparam int ST_ACT_BIT  = 3;
    localparam int ST_EN_BIT   = 19;
    localparam int MAP_TID_LSB = 0;
    localparam int MAP_RCV_LSB = 4;
    localparam int LIM_WIN_LSB = 0;
    localparam int LIM_FL_LSB  = 16;

    typedef enum logic [1:0] {
        CFG_STATUS = 2'd0,
        CFG_MAP    = 2'd1,
        CFG_LIMITS = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic             active;
        logic [TID_W-1:0] tid;
        logic [RCV_W-1:0] rcv;
        logic [LIM_W-1:0] win;
        logic [LIM_W-1:0] flim;
    } qctx_t;

    typedef struct packed {
        logic [Q_W-1:0]   qid;
        logic [CH_W-1:0]  ch;
        logic [PTR_W-1:0] idx;
        logic [TID_W-1:0] tid;
        logic [RCV_W-1:0] rcv;
        logic [LIM_W-1:0] win;
        logic [LIM_W-1:0] flim;
    } grant_t;

    // larger value means higher priority: command channel on top,
    // traffic channels next in numeric order, spare channels last
    function automatic logic [CH_W-1:0] ch_rank(input logic [CH_W-1:0] ch);
        if (ch == CH_W'(CMD_CH))
            return CH_W'(NUM_CH - 1);
        else if (ch < CH_W'(NUM_AC))
            return ch + CH_W'(NUM_CH - 1 - NUM_AC);
        else
            return ch - CH_W'(NUM_AC);
    endfunction
endpackage

// File: rtl/txsched_ctx.sv
module txsched_ctx
    import txsched_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_kind,
    input  logic [Q_W-1:0]               cfg_qid,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic                         wp_we,
    input  logic [Q_W-1:0]               wp_qid,
    input  logic [PTR_W-1:0]             wp_val,
    input  logic                         adv,
    input  logic [Q_W-1:0]               adv_qid,
    output qctx_t [NUM_Q-1:0]            ctx_o,
    output logic [NUM_Q-1:0][PTR_W-1:0]  rd_o,
    output logic [NUM_Q-1:0]             elig_o
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        qctx_t            ctx_r;
        logic [PTR_W-1:0] wr_r;
        logic [PTR_W-1:0] rd_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctx_r <= '{ch: '0, active: 1'b0, tid: '0, rcv: '0,
                           win: LIM_W'(DEF_LIM), flim: LIM_W'(DEF_LIM)};
                wr_r  <= '0;
                rd_r  <= '0;
            end else begin
                if (cfg_we && cfg_qid == Q_W'(q)) begin
                    case (cfg_kind_e'(cfg_kind))
                        CFG_STATUS: if (cfg_wdata[ST_EN_BIT]) begin
                            ctx_r.active <= cfg_wdata[ST_ACT_BIT];
                            if (!ctx_r.active)
                                ctx_r.ch <= cfg_wdata[ST_CH_LSB +: CH_W];
                        end
                        CFG_MAP: begin
                            ctx_r.tid <= cfg_wdata[MAP_TID_LSB +: TID_W];
                            ctx_r.rcv <= cfg_wdata[MAP_RCV_LSB +: RCV_W];
                        end
                        CFG_LIMITS: begin
                            ctx_r.win  <= cfg_wdata[LIM_WIN_LSB +: LIM_W];
                            ctx_r.flim <= cfg_wdata[LIM_FL_LSB +: LIM_W];
                        end
                        default: ;
                    endcase
                end
                if (wp_we && wp_qid == Q_W'(q))
                    wr_r <= wp_val;
                if (adv && adv_qid == Q_W'(q))
                    rd_r <= rd_r + PTR_W'(1);
            end
        end

        assign ctx_o[q]  = ctx_r;
        assign rd_o[q]   = rd_r;
        assign elig_o[q] = ctx_r.active && (wr_r != rd_r);
    end
endmodule

// File: rtl/txsched_rr_pick.sv
module txsched_rr_pick #(
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] pick
);
    always_comb begin
        hit  = 1'b0;
        pick = last;
        for (int i = 1; i <= N; i++) begin
            int c;
            c = (int'(last) + i) % N;
            if (!hit && req[c]) begin
                hit  = 1'b1;
                pick = IW'(c);
            end
        end
    end
endmodule

// File: rtl/txsched_arb.sv
module txsched_arb
    import txsched_pkg::*;
(
    input  logic [NUM_Q-1:0]             elig,
    input  qctx_t [NUM_Q-1:0]            ctx,
    input  logic [NUM_CH-1:0][Q_W-1:0]   last_q,
    output logic                         win_valid,
    output logic [Q_W-1:0]               win_q,
    output logic [CH_W-1:0]              win_ch
);
    logic [NUM_CH-1:0]           ch_hit;
    logic [NUM_CH-1:0][Q_W-1:0]  ch_pick;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_Q-1:0] req_c;
        always_comb begin
            for (int q = 0; q < NUM_Q; q++)
                req_c[q] = elig[q] && (ctx[q].ch == CH_W'(c));
        end
        txsched_rr_pick #(.N(NUM_Q)) u_rr (
            .req  (req_c),
            .last (last_q[c]),
            .hit  (ch_hit[c]),
            .pick (ch_pick[c])
        );
    end

    always_comb begin
        logic [CH_W-1:0] best_rank;
        win_valid = 1'b0;
        win_ch    = '0;
        best_rank = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c] && (!win_valid || ch_rank(CH_W'(c)) > best_rank)) begin
                win_valid = 1'b1;
                win_ch    = CH_W'(c);
                best_rank = ch_rank(CH_W'(c));
            end
        end
        win_q = ch_pick[win_ch];
    end
endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txsched_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_kind,
    input  logic [3:0]  cfg_qid,
    input  logic [31:0] cfg_wdata,
    input  logic        wp_we,
    input  logic [3:0]  wp_qid,
    input  logic [7:0]  wp_val,
    output logic        gnt_valid,
    input  logic        gnt_accept,
    output logic [3:0]  gnt_qid,
    output logic [2:0]  gnt_ch,
    output logic [7:0]  gnt_idx,
    output logic [3:0]  gnt_tid,
    output logic [4:0]  gnt_rcv,
    output logic [6:0]  gnt_win,
    output logic [6:0]  gnt_flim
);
    qctx_t [NUM_Q-1:0]            ctx_vec;
    logic  [NUM_Q-1:0][PTR_W-1:0] rd_vec;
    logic  [NUM_Q-1:0]            elig_vec;
    logic  [NUM_CH-1:0][Q_W-1:0]  last_q;
    logic                         win_valid;
    logic  [Q_W-1:0]              win_q;
    logic  [CH_W-1:0]             win_ch;
    logic                         gnt_v;
    grant_t                       gnt_r;
    logic                         retire;

    assign retire = gnt_v && gnt_accept;

    txsched_ctx u_ctx (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_qid   (cfg_qid),
        .cfg_wdata (cfg_wdata),
        .wp_we     (wp_we),
        .wp_qid    (wp_qid),
        .wp_val    (wp_val),
        .adv       (retire),
        .adv_qid   (gnt_r.qid),
        .ctx_o     (ctx_vec),
        .rd_o      (rd_vec),
        .elig_o    (elig_vec)
    );

    txsched_arb u_arb (
        .elig      (elig_vec),
        .ctx       (ctx_vec),
        .last_q    (last_q),
        .win_valid (win_valid),
        .win_q     (win_q),
        .win_ch    (win_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_v <= 1'b0;
            gnt_r <= '0;
        end else if (gnt_v) begin
            if (gnt_accept)
                gnt_v <= 1'b0;
        end else if (win_valid) begin
            gnt_v      <= 1'b1;
            gnt_r.qid  <= win_q;
            gnt_r.ch   <= win_ch;
            gnt_r.idx  <= rd_vec[win_q];
            gnt_r.tid  <= ctx_vec[win_q].tid;
            gnt_r.rcv  <= ctx_vec[win_q].rcv;
            gnt_r.win  <= ctx_vec[win_q].win;
            gnt_r.flim <= ctx_vec[win_q].flim;
        end
    end

    // round-robin memory per channel: last ring accepted there
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++)
                last_q[c] <= Q_W'(NUM_Q - 1);
        end else if (retire) begin
            last_q[gnt_r.ch] <= gnt_r.qid;
        end
    end

    assign gnt_valid = gnt_v;
    assign gnt_qid   = gnt_r.qid;
    assign gnt_ch    = gnt_r.ch;
    assign gnt_idx   = gnt_r.idx;
    assign gnt_tid   = gnt_r.tid;
    assign gnt_rcv   = gnt_r.rcv;
    assign gnt_win   = gnt_r.win;
    assign gnt_flim  = gnt_r.flim;
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk
    import txsched_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             gnt_valid,
    input logic             gnt_accept,
    input logic [Q_W-1:0]   gnt_qid,
    input logic [PTR_W-1:0] gnt_idx,
    input logic [CH_W-1:0]  gnt_ch,
    input logic [NUM_Q-1:0] elig
);
    logic [NUM_Q-1:0] elig_q;
    always_ff @(posedge clk) begin
        if (rst) elig_q <= '0;
        else     elig_q <= elig;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !gnt_valid);

    p_only_eligible_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_valid) |-> elig_q[gnt_qid]);

    p_hold_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_accept) |=>
            (gnt_valid && $stable(gnt_qid) && $stable(gnt_idx) && $stable(gnt_ch)));

    p_drop_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_accept) |=> !gnt_valid);
endmodule

bind txsched_top txsched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .gnt_valid  (gnt_valid),
    .gnt_accept (gnt_accept),
    .gnt_qid    (gnt_qid),
    .gnt_idx    (gnt_idx),
    .gnt_ch     (gnt_ch),
    .elig       (elig_vec)
);

// File: tb/txsched_top_bench.sv
module txsched_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd3;
    logic [3:0]  cfg_qid = '0;
    logic [31:0] cfg_wdata = '0;
    logic        wp_we = 1'b0;
    logic [3:0]  wp_qid = '0;
    logic [7:0]  wp_val = '0;
    logic        gnt_valid;
    logic        gnt_accept = 1'b0;
    logic [3:0]  gnt_qid;
    logic [2:0]  gnt_ch;
    logic [7:0]  gnt_idx;
    logic [3:0]  gnt_tid;
    logic [4:0]  gnt_rcv;
    logic [6:0]  gnt_win;
    logic [6:0]  gnt_flim;

    always #2 clk = ~clk;   // 250 MHz

    txsched_top u_txsched_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_qid(cfg_qid), .cfg_wdata(cfg_wdata), .wp_we(wp_we),
        .wp_qid(wp_qid), .wp_val(wp_val), .gnt_valid(gnt_valid),
        .gnt_accept(gnt_accept), .gnt_qid(gnt_qid), .gnt_ch(gnt_ch),
        .gnt_idx(gnt_idx), .gnt_tid(gnt_tid), .gnt_rcv(gnt_rcv),
        .gnt_win(gnt_win), .gnt_flim(gnt_flim)
    );

    typedef struct {
        int q; int idx; int ch; int tid; int rcv; int win; int flim;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    auto_acc = 1'b0;
    bit    done = 1'b0;

    localparam int EN  = 1 << 19;
    localparam int ACT = 1 << 3;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int q, input int idx, input int ch, input int tid,
                        input int rcv, input int win, input int flim, input string req);
        exp_t e;
        e.q = q; e.idx = idx; e.ch = ch; e.tid = tid; e.rcv = rcv;
        e.win = win; e.flim = flim; e.req = req;
        sb.push_back(e);
    endtask

    task automatic push_def(input int q, input int idx, input int ch, input string req);
        push(q, idx, ch, 0, 0, 64, 64, req);
    endtask

    task automatic cfg(input int kind, input int q, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_qid = 4'(q); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_kind = 2'd3;
    endtask

    task automatic wptr(input int q, input int val);
        @(negedge clk);
        wp_we = 1'b1; wp_qid = 4'(q); wp_val = 8'(val);
        @(negedge clk);
        wp_we = 1'b0;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        auto_acc = 1'b1;
        while (sb.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        chk(sb.size() == 0, req, "grants still expected", sb.size(), 0);
        sb.delete();
        auto_acc = 1'b0;
    endtask

    // monitor: compare each grant with the scoreboard, then accept it
    initial begin
        forever begin
            @(negedge clk);
            if (auto_acc && gnt_valid) begin
                int q0, i0, c0;
                exp_t e;
                q0 = gnt_qid; i0 = gnt_idx; c0 = gnt_ch;
                @(negedge clk);
                chk(gnt_valid && gnt_qid == 4'(q0) && gnt_idx == 8'(i0) && gnt_ch == 3'(c0),
                    "R5", "grant held before accept", int'(gnt_idx), i0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected grant for ring", int'(gnt_qid), -1);
                end else begin
                    e = sb.pop_front();
                    n_chk++;
                    if (int'(gnt_qid) != e.q || int'(gnt_idx) != e.idx || int'(gnt_ch) != e.ch ||
                        int'(gnt_tid) != e.tid || int'(gnt_rcv) != e.rcv ||
                        int'(gnt_win) != e.win || int'(gnt_flim) != e.flim) begin
                        n_bad++;
                        $display("FAIL %s grant: actual q%0d idx%0d ch%0d tid%0d rcv%0d win%0d flim%0d expected q%0d idx%0d ch%0d tid%0d rcv%0d win%0d flim%0d",
                                 e.req, gnt_qid, gnt_idx, gnt_ch, gnt_tid, gnt_rcv, gnt_win, gnt_flim,
                                 e.q, e.idx, e.ch, e.tid, e.rcv, e.win, e.flim);
                    end
                end
                gnt_accept = 1'b1;
                @(negedge clk);
                gnt_accept = 1'b0;
                chk(!gnt_valid, "R5", "valid low after accept", int'(gnt_valid), 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!gnt_valid, "R1", "valid during reset", int'(gnt_valid), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!gnt_valid, "R1", "valid after reset", int'(gnt_valid), 0);

        // R2: active but empty, then inactive with entries
        cfg(0, 2, EN | ACT | 1);
        repeat (5) @(negedge clk);
        chk(!gnt_valid, "R2", "grant from empty ring", int'(gnt_valid), 0);
        wptr(3, 2);
        repeat (5) @(negedge clk);
        chk(!gnt_valid, "R2", "grant from inactive ring", int'(gnt_valid), 0);

        // R10 + R9 defaults: ring 2 gets three entries
        push_def(2, 0, 1, "R10");
        push_def(2, 1, 1, "R10");
        push_def(2, 2, 1, "R9");
        wptr(2, 3);
        drain("R10");

        // R3: priority across channels, ring 4 grabs the grant first
        cfg(0, 4, EN | ACT | 0);
        wptr(4, 1);
        cfg(0, 5, EN | ACT | 3);
        wptr(5, 1);
        cfg(0, 6, EN | ACT | 7);
        wptr(6, 1);
        cfg(0, 7, EN | ACT | 5);
        wptr(7, 1);
        cfg(0, 8, EN | ACT | 0);
        wptr(8, 1);
        repeat (4) @(negedge clk);
        chk(gnt_valid && gnt_qid == 4'd4, "R5", "held grant ring", int'(gnt_qid), 4);
        push_def(4, 0, 0, "R3");
        push_def(6, 0, 7, "R3");
        push_def(5, 0, 3, "R3");
        push_def(8, 0, 0, "R3");
        push_def(7, 0, 5, "R3");
        drain("R3");

        // R4: round robin on channel 2
        cfg(0, 9, EN | ACT | 2);
        cfg(0, 10, EN | ACT | 2);
        cfg(0, 11, EN | ACT | 2);
        wptr(9, 2);
        wptr(10, 2);
        wptr(11, 2);
        for (int k = 0; k < 2; k++) begin
            push_def(9, k, 2, "R4");
            push_def(10, k, 2, "R4");
            push_def(11, k, 2, "R4");
        end
        drain("R4");

        // R5: read pointer wraps 255 -> 0
        cfg(0, 12, EN | ACT | 1);
        for (int k = 0; k < 200; k++) push_def(12, k, 1, "R5");
        wptr(12, 200);
        drain("R5");
        for (int k = 200; k < 258; k++) push_def(12, k % 256, 1, "R5");
        wptr(12, 2);
        drain("R5");

        // R6: status write without enable is ignored
        cfg(0, 13, ACT | 3);
        wptr(13, 1);
        repeat (6) @(negedge clk);
        chk(!gnt_valid, "R6", "grant after unenabled status write", int'(gnt_valid), 0);
        push_def(13, 0, 3, "R6");
        cfg(0, 13, EN | ACT | 3);
        drain("R6");

        // R7: channel change ignored while active
        cfg(0, 13, EN | ACT | 6);
        push_def(13, 1, 3, "R7");
        wptr(13, 2);
        drain("R7");
        cfg(0, 13, EN | 6);
        cfg(0, 13, EN | ACT | 6);
        push_def(13, 2, 6, "R7");
        wptr(13, 3);
        drain("R7");

        // R8 / R9: map and limits fields
        cfg(1, 14, 5 | (17 << 4));
        cfg(2, 14, 10 | (33 << 16));
        cfg(0, 14, EN | ACT | 0);
        push(14, 0, 0, 5, 17, 10, 33, "R8");
        wptr(14, 1);
        drain("R8");

        repeat (10) @(negedge clk);
        chk(!gnt_valid, "R2", "inactive ring 3 never granted", int'(gnt_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule